// File: doc/BRIEF.md
# PWM Output Fault Shutdown Controller

This block sits between a dead-time PWM generator and the output pads. It watches four fault sources: two event-bus sources, a debugger-halt indication and a core-lockup indication. Each event-bus source takes one channel of a shared event bus, chosen by its own select field. Each source has an enable bit. When an enabled source is high at a clock edge, the block latches that source into a sticky status register. While any status bit is set, the PWM outputs are held in a configured safe state.

Software clears status bits through a write-one-to-clear port. When auto-restart is on, hardware also clears the debugger bit once the halt is released. The outputs return to normal only when every status bit is zero, so an auto-cleared debugger fault never releases outputs while another fault is still recorded. The safe state is chosen by the action field. It drives each output to its inactive level, drives every output low, or turns every output driver off.

Top module: `pwm_fault_guard`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `fault_status` is 0 and `fault_active` is 0.
- R2: A source that is enabled and high at a rising clock edge sets its status bit from that edge on. The status bit positions are the same as the `src_en` bit positions: bit 0 is event source 0, bit 1 is event source 1, bit 2 is debugger halt and bit 3 is core lockup.
- R3: Event source 0 is the channel `evt_ch[evt0_sel]`. Event source 1 is the channel `evt_ch[evt1_sel]`. No other channel affects either source.
- R4: A source whose enable bit is 0 never sets its status bit. Clearing an enable bit does not clear a status bit that is already set.
- R5: A status bit stays set until it is cleared. A clock edge with `clr_we`=1 clears every status bit whose `clr_mask` bit is 1. If the source is still enabled and high at that same edge, the bit stays set.
- R6: With `auto_restart`=1, a clock edge at which `dbg_halt`=0 clears status bit 2. Bits 0, 1 and 3 are never cleared by hardware.
- R7: `fault_active` is the OR of all status bits. The outputs leave the safe state in the same cycle that the status becomes zero, including when only the debugger bit was cleared by hardware.
- R8: Action code 0 (inactive level), while a fault is active: each output equals its `pol_low` bit, so an active-high output is driven low and an active-low output is driven high. `pwm_oe` is all ones.
- R9: Action code 1 (clear), while a fault is active: `pwm_out` is all zeros and `pwm_oe` is all ones.
- R10: Action code 2 (tristate), while a fault is active: `pwm_oe` is all zeros and `pwm_out` is all zeros. Code 3 behaves like code 2.
- R11: With no fault active, `pwm_out` equals `pwm_in` and `pwm_oe` is all ones, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | NUM_OUT | Raw PWM from the dead-time generator |
| pol_low | input | NUM_OUT | 1 marks an output as active-low |
| evt_ch | input | NUM_CH | Event-bus channel levels |
| evt0_sel | input | SEL_W | Channel select for event source 0 |
| evt1_sel | input | SEL_W | Channel select for event source 1 |
| dbg_halt | input | 1 | Debugger has halted the core |
| core_lockup | input | 1 | Core lockup indication |
| src_en | input | 4 | Per-source fault enable |
| act_sel | input | 2 | Safe-state action code |
| auto_restart | input | 1 | Hardware clear of the debugger bit on halt release |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 4 | Write-one-to-clear mask for the status bits |
| pwm_out | output | NUM_OUT | PWM level to the pads |
| pwm_oe | output | NUM_OUT | Per-output driver enable |
| fault_status | output | 4 | Sticky per-source fault status |
| fault_active | output | 1 | Safe state is in force |

## Verification
The hardest situation to reach is a hardware clear of the debugger bit while another status bit is still set, because the outputs must then stay in the safe state. A directed sequence sets the debugger bit and an event bit together and releases the halt with auto-restart on. It then checks that the outputs stay safe until software clears the event bit. A second directed case holds a source high while software clears its bit, so the set-over-clear rule is tested. Random stimulus drives faults rarely and clears often, so the block moves through many enter and leave transitions under all four action codes.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

    localparam int unsigned NSRC = 4;

    localparam int unsigned SRC_EVT0 = 0;
    localparam int unsigned SRC_EVT1 = 1;
    localparam int unsigned SRC_DBG  = 2;
    localparam int unsigned SRC_LOCK = 3;

    typedef enum logic [1:0] {
        ACT_INACTIVE = 2'd0,
        ACT_CLEAR    = 2'd1,
        ACT_TRISTATE = 2'd2,
        ACT_RESERVED = 2'd3
    } safe_act_e;

    typedef struct packed {
        logic lockup;
        logic dbg;
        logic evt1;
        logic evt0;
    } fsrc_t;

    typedef struct packed {
        logic drive;
        logic level;
    } pin_t;

    function automatic pin_t safe_pin(input safe_act_e act, input logic low_active);
        pin_t p;
        unique case (act)
            ACT_INACTIVE: begin p.drive = 1'b1; p.level = low_active; end
            ACT_CLEAR:    begin p.drive = 1'b1; p.level = 1'b0;       end
            default:      begin p.drive = 1'b0; p.level = 1'b0;       end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/fault_src_sampler.sv
module fault_src_sampler
    import pwm_fault_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] evt_ch,
    input  logic [SEL_W-1:0]  evt0_sel,
    input  logic [SEL_W-1:0]  evt1_sel,
    input  logic              dbg_halt,
    input  logic              core_lockup,
    input  logic [NSRC-1:0]   src_en,
    output fsrc_t             hit
);
    localparam int unsigned NEVT = 2;

    logic [SEL_W-1:0] sel_arr [NEVT];
    logic [NEVT-1:0]  evt_lvl;

    assign sel_arr[0] = evt0_sel;
    assign sel_arr[1] = evt1_sel;

    for (genvar e = 0; e < NEVT; e++) begin : g_evt
        always_comb begin
            evt_lvl[e] = 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                if (sel_arr[e] == SEL_W'(c)) evt_lvl[e] = evt_ch[c];
            end
        end
    end

    always_comb begin
        hit.evt0   = evt_lvl[0]  & src_en[SRC_EVT0];
        hit.evt1   = evt_lvl[1]  & src_en[SRC_EVT1];
        hit.dbg    = dbg_halt    & src_en[SRC_DBG];
        hit.lockup = core_lockup & src_en[SRC_LOCK];
    end

endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
    import pwm_fault_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  fsrc_t           hit,
    input  logic            dbg_halt,
    input  logic            auto_restart,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_mask,
    output fsrc_t           status,
    output logic            any_fault
);
    fsrc_t sw_clr;
    fsrc_t hw_clr;
    fsrc_t status_d;

    always_comb begin
        sw_clr = clr_we ? fsrc_t'(clr_mask) : '0;
        hw_clr = '0;
        hw_clr.dbg = auto_restart & ~dbg_halt;
        status_d = (status & ~(sw_clr | hw_clr)) | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= status_d;
    end

    assign any_fault = |status;

endmodule

// File: rtl/pwm_safe_drive.sv
module pwm_safe_drive
    import pwm_fault_pkg::*;
#(
    parameter int unsigned NUM_OUT = 6
) (
    input  logic [NUM_OUT-1:0] pwm_in,
    input  logic [NUM_OUT-1:0] pol_low,
    input  logic [1:0]         act_sel,
    input  logic               any_fault,
    output logic [NUM_OUT-1:0] pwm_out,
    output logic [NUM_OUT-1:0] pwm_oe
);
    safe_act_e act;
    assign act = safe_act_e'(act_sel);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
        pin_t safe;
        always_comb begin
            safe = safe_pin(act, pol_low[i]);
            if (any_fault) begin
                pwm_out[i] = safe.level;
                pwm_oe[i]  = safe.drive;
            end else begin
                pwm_out[i] = pwm_in[i];
                pwm_oe[i]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
    import pwm_fault_pkg::*;
#(
    parameter int unsigned NUM_OUT = 6,
    parameter int unsigned NUM_CH  = 8,
    localparam int unsigned SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OUT-1:0] pwm_in,
    input  logic [NUM_OUT-1:0] pol_low,
    input  logic [NUM_CH-1:0]  evt_ch,
    input  logic [SEL_W-1:0]   evt0_sel,
    input  logic [SEL_W-1:0]   evt1_sel,
    input  logic               dbg_halt,
    input  logic               core_lockup,
    input  logic [3:0]         src_en,
    input  logic [1:0]         act_sel,
    input  logic               auto_restart,
    input  logic               clr_we,
    input  logic [3:0]         clr_mask,
    output logic [NUM_OUT-1:0] pwm_out,
    output logic [NUM_OUT-1:0] pwm_oe,
    output logic [3:0]         fault_status,
    output logic               fault_active
);
    fsrc_t hit;
    fsrc_t status;
    logic  any_fault;

    fault_src_sampler #(.NUM_CH(NUM_CH)) u_sampler (
        .evt_ch      (evt_ch),
        .evt0_sel    (evt0_sel),
        .evt1_sel    (evt1_sel),
        .dbg_halt    (dbg_halt),
        .core_lockup (core_lockup),
        .src_en      (src_en),
        .hit         (hit)
    );

    fault_status_reg u_status (
        .clk          (clk),
        .rst          (rst),
        .hit          (hit),
        .dbg_halt     (dbg_halt),
        .auto_restart (auto_restart),
        .clr_we       (clr_we),
        .clr_mask     (clr_mask),
        .status       (status),
        .any_fault    (any_fault)
    );

    pwm_safe_drive #(.NUM_OUT(NUM_OUT)) u_drive (
        .pwm_in    (pwm_in),
        .pol_low   (pol_low),
        .act_sel   (act_sel),
        .any_fault (any_fault),
        .pwm_out   (pwm_out),
        .pwm_oe    (pwm_oe)
    );

    assign fault_status = status;
    assign fault_active = any_fault;

endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk #(
    parameter int unsigned NUM_OUT = 6,
    parameter int unsigned NUM_CH  = 8,
    localparam int unsigned SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_OUT-1:0] pwm_in,
    input logic [NUM_OUT-1:0] pol_low,
    input logic [NUM_CH-1:0]  evt_ch,
    input logic [SEL_W-1:0]   evt0_sel,
    input logic [SEL_W-1:0]   evt1_sel,
    input logic               dbg_halt,
    input logic               core_lockup,
    input logic [3:0]         src_en,
    input logic [1:0]         act_sel,
    input logic               auto_restart,
    input logic               clr_we,
    input logic [3:0]         clr_mask,
    input logic [NUM_OUT-1:0] pwm_out,
    input logic [NUM_OUT-1:0] pwm_oe,
    input logic [3:0]         fault_status,
    input logic               fault_active
);
    logic [3:0] armed;
    assign armed = {core_lockup, dbg_halt, evt_ch[evt1_sel], evt_ch[evt0_sel]} & src_en;

    // R2: an armed source is latched at the edge
    p_armed_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (armed != 4'd0) |=> ((fault_status & $past(armed)) == $past(armed)));

    // R4: a newly set bit must come from an armed source
    p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fault_status & ~$past(fault_status) & ~$past(armed)) == 4'd0));

    // R5: event bits hold without a software clear
    p_evt_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (fault_status[1:0] != 2'd0 && !clr_we)
        |=> ((fault_status[1:0] & $past(fault_status[1:0])) == $past(fault_status[1:0])));

    // R6: hardware never clears the lockup bit
    p_lock_hw_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (fault_status[3] && !(clr_we && clr_mask[3])) |=> fault_status[3]);

    // R7: active flag tracks the status
    p_active_r7: assert property (@(posedge clk) disable iff (rst)
        fault_active == (fault_status != 4'd0));

    // R9: clear action
    p_clear_act_r9: assert property (@(posedge clk) disable iff (rst)
        (fault_active && act_sel == 2'd1) |-> (pwm_out == '0 && pwm_oe == '1));

    // R10: tristate action
    p_tristate_r10: assert property (@(posedge clk) disable iff (rst)
        (fault_active && act_sel[1]) |-> (pwm_oe == '0));

    // R11: pass-through when healthy
    p_pass_r11: assert property (@(posedge clk) disable iff (rst)
        !fault_active |-> (pwm_out == pwm_in && pwm_oe == '1));

    // R8: inactive-level action
    p_inactive_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_active && act_sel == 2'd0) |-> (pwm_out == pol_low && pwm_oe == '1));

endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(.NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/sim_pwm_fault_guard.sv
module sim_pwm_fault_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NO = 6;
    localparam int NC = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [NO-1:0] pwm_in, pol_low, pwm_out, pwm_oe;
    logic [NC-1:0] evt_ch;
    logic [SW-1:0] evt0_sel, evt1_sel;
    logic          dbg_halt, core_lockup, auto_restart, clr_we, fault_active;
    logic [3:0]    src_en, clr_mask, fault_status;
    logic [1:0]    act_sel;

    int checks = 0;
    int fails  = 0;
    logic [3:0] exp_st;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_fault_guard #(.NUM_OUT(NO), .NUM_CH(NC)) u0 (.*);

    function automatic logic [3:0] model_next(input logic [3:0] st);
        logic [3:0] raw, clr;
        raw = {core_lockup, dbg_halt, evt_ch[evt1_sel], evt_ch[evt0_sel]} & src_en;
        clr = clr_we ? clr_mask : 4'd0;
        if (auto_restart && !dbg_halt) clr[2] = 1'b1;
        return (st & ~clr) | raw;
    endfunction

    function automatic logic [2*NO-1:0] model_pins(input logic [3:0] st);
        if (st == 4'd0) return {pwm_in, {NO{1'b1}}};
        case (act_sel)
            2'd0:    return {pol_low, {NO{1'b1}}};
            2'd1:    return {{NO{1'b0}}, {NO{1'b1}}};
            default: return {{NO{1'b0}}, {NO{1'b0}}};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [2*NO-1:0] p;
        p = model_pins(exp_st);
        chk({tag, " status R2/R5"}, 32'(fault_status), 32'(exp_st));
        chk({tag, " active R7"}, 32'(fault_active), 32'(exp_st != 0));
        chk({tag, " pins R8/R9/R10/R11"}, 32'({pwm_out, pwm_oe}), 32'(p));
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        exp_st = model_next(exp_st);
        @(negedge clk);
        check_all(tag);
        clr_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; pwm_in = '0; pol_low = '0; evt_ch = '0; evt0_sel = '0; evt1_sel = '0;
        dbg_halt = 0; core_lockup = 0; src_en = '0; act_sel = '0; auto_restart = 0;
        clr_we = 0; clr_mask = '0; exp_st = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 status in reset", 32'(fault_status), 0);
        rst = 1'b0;
        pwm_in = 6'b101100;
        cycle("R1 after reset");
        chk("R11 passthrough", 32'(pwm_out), 32'(6'b101100));

        // R3: channel select, R2: set
        src_en = 4'b0011; evt0_sel = 3'd5; evt1_sel = 3'd2;
        evt_ch = 8'b1101_1011;
        cycle("R3 unselected channels");
        chk("R3 no fault from other channels", 32'(fault_status), 0);
        evt_ch = 8'b0010_0000;
        cycle("R3 channel 5");
        chk("R3 evt0 bit set", 32'(fault_status), 32'(4'b0001));
        evt_ch = '0;

        // R8: inactive level per polarity
        act_sel = 2'd0; pol_low = 6'b110010; pwm_in = 6'b011011;
        @(negedge clk);
        chk("R8 inactive level", 32'(pwm_out), 32'(6'b110010));

        // R5: set wins over clear
        evt_ch = 8'b0010_0000; clr_we = 1; clr_mask = 4'b0001;
        cycle("R5 set over clear");
        chk("R5 bit kept", 32'(fault_status[0]), 1);
        evt_ch = '0; clr_we = 1; clr_mask = 4'b0001;
        cycle("R5 sw clear");
        chk("R7 released same cycle", 32'(pwm_out), 32'(6'b011011));

        // R4: disabled source and disabling a set bit
        src_en = 4'b0000; core_lockup = 1; dbg_halt = 1;
        cycle("R4 disabled");
        chk("R4 no set when disabled", 32'(fault_status), 0);
        src_en = 4'b1000;
        cycle("R4 lockup set");
        core_lockup = 0; src_en = 4'b0000;
        cycle("R4 disable keeps bit");
        chk("R4 bit kept", 32'(fault_status), 32'(4'b1000));
        act_sel = 2'd3;
        @(negedge clk);
        chk("R10 reserved code tristates", 32'(pwm_oe), 0);
        clr_we = 1; clr_mask = 4'b1111;
        cycle("R5 clear all");

        // R6: auto restart while another bit set
        src_en = 4'b0111; auto_restart = 1; act_sel = 2'd1;
        dbg_halt = 1; evt_ch = 8'b0000_0100;
        cycle("R6 dbg and evt1");
        chk("R6 both bits", 32'(fault_status), 32'(4'b0110));
        evt_ch = '0; dbg_halt = 0;
        cycle("R6 hw clear dbg");
        chk("R6 dbg cleared evt1 kept", 32'(fault_status), 32'(4'b0010));
        chk("R7 still safe", 32'(pwm_out), 0);
        clr_we = 1; clr_mask = 4'b0010;
        cycle("R7 exit after sw clear");
        chk("R7 exited", 32'(fault_active), 0);
        dbg_halt = 1;
        cycle("R6 dbg alone");
        dbg_halt = 0;
        cycle("R6 dbg alone release");
        chk("R6 auto exit", 32'(fault_active), 0);
        auto_restart = 0; dbg_halt = 1;
        cycle("R6 no auto");
        dbg_halt = 0;
        cycle("R6 no auto hold");
        chk("R6 bit stays without auto", 32'(fault_status), 32'(4'b0100));

        // random phase
        for (int n = 0; n < 2000; n++) begin
            pwm_in = NO'($urandom); pol_low = NO'($urandom);
            evt_ch = (($urandom % 8) == 0) ? NC'($urandom) : '0;
            evt0_sel = SW'($urandom); evt1_sel = SW'($urandom);
            dbg_halt = (($urandom % 6) == 0);
            core_lockup = (($urandom % 20) == 0);
            src_en = 4'($urandom); act_sel = 2'($urandom);
            auto_restart = 1'($urandom);
            clr_we = (($urandom % 3) == 0); clr_mask = 4'($urandom);
            cycle("random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule